// File: doc/BRIEF.md
# DDR SDRAM Command Timing Monitor

This block sits beside a DDR SDRAM command bus and watches it one clock at a time. From chip select and the three active-low strobes it decodes one command per cycle. It keeps the open or idle state of each of four banks, including rows that are closing on their own through auto-precharge. It also keeps elapsed-cycle counters per bank and for the whole bus, and checks every command against minimum spacing rules and against the longest time a row may stay open.

The first rule that is broken raises a sticky flag and stores that rule's code. The flag stays set until the host pulses a synchronous clear. All timing limits are parameters in clock cycles. The defaults suit a 7.5 ns clock. The monitor never drives the bus. Its outputs are meant for a checker, a trace unit or an error interrupt, and they are plain status with no handshake.

Top module: `sdram_cmd_guard`

## Requirements
- R1: With `cs_n` low, `{ras_n,cas_n,we_n}` decodes as ACT=011, READ=101, WRITE=100, PRE=010, REF=001 and MRS=000. Any other pattern is a NOP. `cmd_code` shows NOP=0, ACT=1, READ=2, WRITE=3, PRE=4, REF=5 or MRS=6 one cycle after the command is sampled. With `cs_n` high the cycle is a NOP and opens, closes or arms nothing.
- R2: The bank number is `{ba[0],ba[1]}`, where `ba[0]` is the high bit. So BA1=0,BA0=0 is bank 0, BA1=1,BA0=0 is bank 1, BA1=0,BA0=1 is bank 2 and BA1=1,BA0=1 is bank 3. An ACT sets `bank_open[bank]` from the next cycle.
- R3: A PRE with `a10` high closes every bank. A PRE with `a10` low closes only the addressed bank.
- R4: A READ or WRITE with `a10` high, to an open bank with no close pending, makes that bank close by itself. The close happens BURST_CYC cycles after a READ and BURST_CYC+T_WR cycles after a WRITE. Until then `bank_open` still shows the bank as open.
- R5: Violation code 1 (illegal sequence) is raised by any of these: an ACT to an open bank; a READ or WRITE to an idle bank or to a bank with a pending auto-close; a PRE that covers a bank with a pending auto-close; a REF or MRS while any bank is open.
- R6: An ACT raises code 5 if it comes fewer than T_RC cycles after the last ACT to the same bank. It raises code 4 if it comes fewer than T_RP cycles after that bank closed. It raises code 6 if it comes fewer than T_RRD cycles after an ACT to a different bank.
- R7: A READ or WRITE to an open bank fewer than T_RCD cycles after that bank's ACT raises code 3.
- R8: Closing an open bank by PRE fewer than T_RAS_MIN cycles after its ACT raises code 7. A bank that stays open more than T_RAS_MAX cycles raises code 10, and no command is needed for that.
- R9: A PRE that closes a bank fewer than BURST_CYC+T_WR cycles after a WRITE to that bank raises code 8. A READ fewer than BURST_CYC+T_WTR cycles after any WRITE raises code 9.
- R10: Any command other than a NOP fewer than T_MRD cycles after an MRS raises code 2.
- R11: `viol_flag` is set in the cycle after the first violation and then holds, together with `viol_code`. If several rules break in the same cycle, the lowest code is stored. A `clr_viol` pulse clears both outputs on the next edge and wins over a violation in the same cycle.
- R12: While reset is asserted, `cmd_code`, `bank_open`, `viol_flag` and `viol_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_viol | input | 1 | Synchronous clear of the sticky violation |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address: bit 0 is BA0, bit 1 is BA1 |
| a10 | input | 1 | Precharge-all or auto-precharge select |
| cmd_code | output | 3 | Decoded command of the previous cycle |
| bank_open | output | 4 | One bit per bank, 1 = row open |
| viol_flag | output | 1 | Sticky violation flag |
| viol_code | output | 4 | Code of the first broken rule, 0 if none |

## Verification
Some behaviours are checked on every cycle by properties. A deselected cycle decodes as a NOP. An ACT opens the addressed bank, and a precharge-all leaves every bank idle. A READ to an idle bank raises the illegal-sequence code, and the flag and code hold until a clear. The spacing rules are different: their thresholds depend on counters set cycles earlier. These rules, the auto-close instant and the open-row limit are shown only by the bench scenarios. There, a timestamp-based model predicts the state and the first violation code for directed sequences and for long random command streams.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } cmd_e;

  // lower value = higher priority when several rules break together
  typedef enum logic [3:0] {
    V_NONE    = 4'd0,
    V_ILLEGAL = 4'd1,
    V_MRD     = 4'd2,
    V_RCD     = 4'd3,
    V_RP      = 4'd4,
    V_RC      = 4'd5,
    V_RRD     = 4'd6,
    V_RAS_MIN = 4'd7,
    V_WR      = 4'd8,
    V_WTR     = 4'd9,
    V_RAS_MAX = 4'd10
  } viol_e;

  typedef struct packed {
    logic illegal;
    logic rcd;
    logic rp;
    logic rc;
    logic ras_min;
    logic wr;
    logic ras_max;
  } bank_viol_t;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_guard_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_guard_pkg::*;
#(
  parameter int unsigned BANK      = 0,
  parameter int unsigned CW        = 8,
  parameter int unsigned T_RC      = 9,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RAS_MIN = 6,
  parameter int unsigned T_RAS_MAX = 100,
  parameter int unsigned T_WR      = 2,
  parameter int unsigned BURST_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cmd_e       cmd,
  input  logic [1:0] bank_idx,
  input  logic       a10,
  output logic       is_open,
  output bank_viol_t viol
);

  localparam logic [CW-1:0] SAT      = CW'(T_RAS_MAX + 1);
  localparam logic [CW-1:0] L_RC     = CW'(T_RC);
  localparam logic [CW-1:0] L_RCD    = CW'(T_RCD);
  localparam logic [CW-1:0] L_RP     = CW'(T_RP);
  localparam logic [CW-1:0] L_RASMIN = CW'(T_RAS_MIN);
  localparam logic [CW-1:0] L_RASMAX = CW'(T_RAS_MAX);
  localparam logic [CW-1:0] L_WRP    = CW'(BURST_CYC + T_WR);
  localparam logic [CW-1:0] L_AP_RD  = CW'(BURST_CYC);
  localparam logic [CW-1:0] L_AP_WR  = CW'(BURST_CYC + T_WR);
  localparam logic [CW-1:0] ONE      = CW'(1);

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v >= SAT) ? SAT : v + ONE;
  endfunction

  logic          open_q, ap_q;
  logic [CW-1:0] ap_cnt, since_act, since_close, since_wr;
  logic          hit, do_act, do_rw, do_pre, ap_done;

  assign hit     = (bank_idx == 2'(BANK));
  assign do_act  = (cmd == CMD_ACT) && hit;
  assign do_rw   = ((cmd == CMD_RD) || (cmd == CMD_WR)) && hit;
  assign do_pre  = (cmd == CMD_PRE) && (a10 || hit);
  assign ap_done = ap_q && (ap_cnt == ONE);
  assign is_open = open_q;

  always_comb begin
    viol         = '0;
    viol.illegal = (do_act && open_q) || (do_rw && (!open_q || ap_q)) || (do_pre && ap_q);
    viol.rc      = do_act && (since_act < L_RC);
    viol.rp      = do_act && (since_close < L_RP);
    viol.rcd     = do_rw && open_q && (since_act < L_RCD);
    viol.ras_min = do_pre && open_q && !ap_q && (since_act < L_RASMIN);
    viol.wr      = do_pre && open_q && (since_wr < L_WRP);
    viol.ras_max = open_q && (since_act > L_RASMAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q      <= 1'b0;
      ap_q        <= 1'b0;
      ap_cnt      <= '0;
      since_act   <= SAT;
      since_close <= SAT;
      since_wr    <= SAT;
    end else begin
      since_act   <= sat_inc(since_act);
      since_close <= sat_inc(since_close);
      since_wr    <= sat_inc(since_wr);
      if (ap_q) ap_cnt <= ap_cnt - ONE;
      if (ap_done || (do_pre && open_q)) begin
        open_q      <= 1'b0;
        ap_q        <= 1'b0;
        since_close <= ONE;
      end
      if (do_rw && (cmd == CMD_WR)) since_wr <= ONE;
      if (do_rw && open_q && !ap_q && a10) begin
        ap_q   <= 1'b1;
        ap_cnt <= (cmd == CMD_WR) ? L_AP_WR : L_AP_RD;
      end
      if (do_act) begin
        open_q    <= 1'b1;
        ap_q      <= 1'b0;
        since_act <= ONE;
      end
    end
  end

endmodule

// File: rtl/sdram_global_timer.sv
module sdram_global_timer
  import sdram_guard_pkg::*;
#(
  parameter int unsigned CW        = 8,
  parameter int unsigned NB        = 4,
  parameter int unsigned T_RRD     = 2,
  parameter int unsigned T_WTR     = 1,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned BURST_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_e          cmd,
  input  logic [1:0]    bank_idx,
  input  logic [NB-1:0] busy,
  output logic          v_illegal,
  output logic          v_rrd,
  output logic          v_wtr,
  output logic          v_mrd
);

  localparam int unsigned LIM = (T_RRD > BURST_CYC + T_WTR) ? T_RRD : BURST_CYC + T_WTR;
  localparam logic [CW-1:0] SAT    = CW'(((LIM > T_MRD) ? LIM : T_MRD) + 1);
  localparam logic [CW-1:0] L_RRD  = CW'(T_RRD);
  localparam logic [CW-1:0] L_WTRP = CW'(BURST_CYC + T_WTR);
  localparam logic [CW-1:0] L_MRD  = CW'(T_MRD);
  localparam logic [CW-1:0] ONE    = CW'(1);

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v >= SAT) ? SAT : v + ONE;
  endfunction

  logic [CW-1:0] since_act_any, since_wr_any, since_mrs;
  logic [1:0]    last_bank;

  assign v_illegal = ((cmd == CMD_REF) || (cmd == CMD_MRS)) && (|busy);
  assign v_rrd     = (cmd == CMD_ACT) && (since_act_any < L_RRD) && (last_bank != bank_idx);
  assign v_wtr     = (cmd == CMD_RD) && (since_wr_any < L_WTRP);
  assign v_mrd     = (cmd != CMD_NOP) && (since_mrs < L_MRD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act_any <= SAT;
      since_wr_any  <= SAT;
      since_mrs     <= SAT;
      last_bank     <= '0;
    end else begin
      since_act_any <= sat_inc(since_act_any);
      since_wr_any  <= sat_inc(since_wr_any);
      since_mrs     <= sat_inc(since_mrs);
      if (cmd == CMD_ACT) begin
        since_act_any <= ONE;
        last_bank     <= bank_idx;
      end
      if (cmd == CMD_WR)  since_wr_any <= ONE;
      if (cmd == CMD_MRS) since_mrs    <= ONE;
    end
  end

endmodule

// File: rtl/sdram_viol_latch.sv
module sdram_viol_latch
  import sdram_guard_pkg::*;
#(
  parameter int unsigned NB = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  bank_viol_t [NB-1:0] bv,
  input  logic                g_illegal,
  input  logic                g_rrd,
  input  logic                g_wtr,
  input  logic                g_mrd,
  output logic                flag,
  output logic [3:0]          code
);

  bank_viol_t any_b;
  viol_e      first;

  always_comb begin
    any_b = '0;
    for (int i = 0; i < int'(NB); i++) any_b = any_b | bv[i];
  end

  always_comb begin
    if (any_b.illegal || g_illegal) first = V_ILLEGAL;
    else if (g_mrd)                 first = V_MRD;
    else if (any_b.rcd)             first = V_RCD;
    else if (any_b.rp)              first = V_RP;
    else if (any_b.rc)              first = V_RC;
    else if (g_rrd)                 first = V_RRD;
    else if (any_b.ras_min)         first = V_RAS_MIN;
    else if (any_b.wr)              first = V_WR;
    else if (g_wtr)                 first = V_WTR;
    else if (any_b.ras_max)         first = V_RAS_MAX;
    else                            first = V_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      code <= '0;
    end else if (clr) begin
      flag <= 1'b0;
      code <= '0;
    end else if (!flag && (first != V_NONE)) begin
      flag <= 1'b1;
      code <= first;
    end
  end

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdram_guard_pkg::*;
#(
  parameter int unsigned T_RC      = 9,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RRD     = 2,
  parameter int unsigned T_RAS_MIN = 6,
  parameter int unsigned T_RAS_MAX = 16000,
  parameter int unsigned T_WR      = 2,
  parameter int unsigned T_WTR     = 1,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned BURST_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_viol,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic [1:0] ba,
  input  logic       a10,
  output logic [2:0] cmd_code,
  output logic [3:0] bank_open,
  output logic       viol_flag,
  output logic [3:0] viol_code
);

  localparam int unsigned NB = 4;
  localparam int unsigned CW = $clog2(T_RAS_MAX + 2);

  cmd_e                cmd;
  logic [1:0]          bank_idx;
  logic [NB-1:0]       open_vec;
  bank_viol_t [NB-1:0] bviol;
  logic                g_illegal, g_rrd, g_wtr, g_mrd;

  assign bank_idx = {ba[0], ba[1]};

  sdram_cmd_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (cmd)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sdram_bank_tracker #(
      .BANK     (b),
      .CW       (CW),
      .T_RC     (T_RC),
      .T_RCD    (T_RCD),
      .T_RP     (T_RP),
      .T_RAS_MIN(T_RAS_MIN),
      .T_RAS_MAX(T_RAS_MAX),
      .T_WR     (T_WR),
      .BURST_CYC(BURST_CYC)
    ) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .bank_idx(bank_idx),
      .a10     (a10),
      .is_open (open_vec[b]),
      .viol    (bviol[b])
    );
  end

  sdram_global_timer #(
    .CW       (CW),
    .NB       (NB),
    .T_RRD    (T_RRD),
    .T_WTR    (T_WTR),
    .T_MRD    (T_MRD),
    .BURST_CYC(BURST_CYC)
  ) u_glob (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .bank_idx (bank_idx),
    .busy     (open_vec),
    .v_illegal(g_illegal),
    .v_rrd    (g_rrd),
    .v_wtr    (g_wtr),
    .v_mrd    (g_mrd)
  );

  sdram_viol_latch #(.NB(NB)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_viol),
    .bv       (bviol),
    .g_illegal(g_illegal),
    .g_rrd    (g_rrd),
    .g_wtr    (g_wtr),
    .g_mrd    (g_mrd),
    .flag     (viol_flag),
    .code     (viol_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_code <= '0;
    else        cmd_code <= cmd;
  end

  assign bank_open = open_vec;

endmodule

// File: rtl/sdram_cmd_guard_chk.sv
module sdram_cmd_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_viol,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [1:0] ba,
  input logic       a10,
  input logic [2:0] cmd_code,
  input logic [3:0] bank_open,
  input logic       viol_flag,
  input logic [3:0] viol_code
);

  logic [1:0] cur_idx;
  logic       sel_act, sel_rd, sel_pre;

  assign cur_idx = {ba[0], ba[1]};
  assign sel_act = !cs_n && ({ras_n, cas_n, we_n} == 3'b011);
  assign sel_rd  = !cs_n && ({ras_n, cas_n, we_n} == 3'b101);
  assign sel_pre = !cs_n && ({ras_n, cas_n, we_n} == 3'b010);

  // R1: a deselected cycle decodes as NOP
  p_deselect_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cmd_code == 3'd0));

  // R1: a deselected cycle cannot open a bank
  p_deselect_no_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && (bank_open == 4'b0000)) |=> (bank_open == 4'b0000));

  // R2: an ACT opens the addressed bank
  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_act |=> bank_open[$past(cur_idx)]);

  // R3: precharge-all leaves every bank idle
  p_pre_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_pre && a10) |=> (bank_open == 4'b0000));

  // R5: a READ to an idle bank raises the illegal-sequence code
  p_read_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rd && !bank_open[cur_idx] && !viol_flag && !clr_viol)
      |=> (viol_flag && (viol_code == 4'd1)));

  // R11: flag and code hold until cleared
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !clr_viol) |=> (viol_flag && $stable(viol_code)));

  // R11: a clear pulse wins
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_viol |=> (!viol_flag && (viol_code == 4'd0)));

endmodule

bind sdram_cmd_guard sdram_cmd_guard_chk u_chk (.*);

// File: tb/sdram_cmd_guard_test.sv
module sdram_cmd_guard_test;

  localparam int T_RC = 9, T_RCD = 3, T_RP = 3, T_RRD = 2, T_RAS_MIN = 6;
  localparam int T_RAS_MAX = 40, T_WR = 2, T_WTR = 1, T_MRD = 2, BURST_CYC = 2;
  localparam bit [2:0] P_NOP = 3'b111, P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100;
  localparam bit [2:0] P_PRE = 3'b010, P_REF = 3'b001, P_MRS = 3'b000;

  logic clk = 1'b0, rst_n = 1'b0, clr_viol = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'b00;
  logic [2:0] cmd_code;
  logic [3:0] bank_open, viol_code;
  logic viol_flag;

  int checks = 0, errors = 0, wd = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sdram_cmd_guard #(.T_RAS_MAX(T_RAS_MAX)) uut (
    .clk(clk), .rst_n(rst_n), .clr_viol(clr_viol), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .cmd_code(cmd_code),
    .bank_open(bank_open), .viol_flag(viol_flag), .viol_code(viol_code)
  );

  // timestamp reference model
  int cyc = 0;
  bit m_open[4], m_ap[4];
  int m_apend[4], m_tact[4], m_tclose[4], m_twr[4];
  int m_tact_any, m_last_bank, m_twr_any, m_tmrs;
  bit m_flag;
  int m_code, m_cmd;

  function automatic int dec_cmd(bit cs, bit [2:0] p);
    if (cs) return 0;
    case (p)
      P_ACT: return 1;
      P_RD:  return 2;
      P_WR:  return 3;
      P_PRE: return 4;
      P_REF: return 5;
      P_MRS: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic bit [3:0] m_vec();
    bit [3:0] v;
    for (int k = 0; k < 4; k++) v[k] = m_open[k];
    return v;
  endfunction

  task automatic model_init();
    for (int k = 0; k < 4; k++) begin
      m_open[k] = 0; m_ap[k] = 0; m_apend[k] = -1;
      m_tact[k] = -100000; m_tclose[k] = -100000; m_twr[k] = -100000;
    end
    m_tact_any = -100000; m_last_bank = 0; m_twr_any = -100000; m_tmrs = -100000;
    m_flag = 0; m_code = 0; m_cmd = 0; cyc = 0;
  endtask

  task automatic model_step(bit cs, bit [2:0] p, bit [1:0] bav, bit a, bit clr);
    int c, b, code;
    bit ill, mrd, rcd, rp, rc, rrd, rasmin, wr, wtr, rasmax, busy;
    cyc++;
    c = dec_cmd(cs, p);
    b = {bav[0], bav[1]};
    {ill, mrd, rcd, rp, rc, rrd, rasmin, wr, wtr, rasmax, busy} = '0;
    for (int k = 0; k < 4; k++) begin
      bit hit, act, rw, pre;
      hit = (k == b); act = (c == 1) && hit; rw = (c == 2 || c == 3) && hit;
      pre = (c == 4) && (a || hit);
      busy |= m_open[k];
      if (act && m_open[k]) ill = 1;
      if (rw && (!m_open[k] || m_ap[k])) ill = 1;
      if (pre && m_ap[k]) ill = 1;
      if (act && cyc - m_tact[k] < T_RC) rc = 1;
      if (act && cyc - m_tclose[k] < T_RP) rp = 1;
      if (rw && m_open[k] && cyc - m_tact[k] < T_RCD) rcd = 1;
      if (pre && m_open[k] && !m_ap[k] && cyc - m_tact[k] < T_RAS_MIN) rasmin = 1;
      if (pre && m_open[k] && cyc - m_twr[k] < BURST_CYC + T_WR) wr = 1;
      if (m_open[k] && cyc - m_tact[k] > T_RAS_MAX) rasmax = 1;
    end
    if ((c == 5 || c == 6) && busy) ill = 1;
    if (c == 1 && cyc - m_tact_any < T_RRD && m_last_bank != b) rrd = 1;
    if (c == 2 && cyc - m_twr_any < BURST_CYC + T_WTR) wtr = 1;
    if (c != 0 && cyc - m_tmrs < T_MRD) mrd = 1;
    code = ill ? 1 : mrd ? 2 : rcd ? 3 : rp ? 4 : rc ? 5 : rrd ? 6 :
           rasmin ? 7 : wr ? 8 : wtr ? 9 : rasmax ? 10 : 0;
    if (clr) begin m_flag = 0; m_code = 0; end
    else if (!m_flag && code != 0) begin m_flag = 1; m_code = code; end
    for (int k = 0; k < 4; k++) begin
      bit hit, was_open, was_ap;
      hit = (k == b); was_open = m_open[k]; was_ap = m_ap[k];
      if ((was_ap && m_apend[k] == cyc) || (c == 4 && (a || hit) && was_open)) begin
        m_open[k] = 0; m_ap[k] = 0; m_tclose[k] = cyc;
      end
      if (c == 3 && hit) m_twr[k] = cyc;
      if ((c == 2 || c == 3) && hit && was_open && !was_ap && a) begin
        m_ap[k] = 1; m_apend[k] = cyc + ((c == 3) ? BURST_CYC + T_WR : BURST_CYC);
      end
      if (c == 1 && hit) begin m_open[k] = 1; m_ap[k] = 0; m_tact[k] = cyc; end
    end
    if (c == 1) begin m_tact_any = cyc; m_last_bank = b; end
    if (c == 3) m_twr_any = cyc;
    if (c == 6) m_tmrs = cyc;
    m_cmd = c;
  endtask

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // called at a negedge: drive, let one edge pass, compare with model
  task automatic step(bit cs, bit [2:0] p, bit [1:0] bav, bit a, bit clr, string tag);
    cs_n = cs; {ras_n, cas_n, we_n} = p; ba = bav; a10 = a; clr_viol = clr;
    @(posedge clk);
    model_step(cs, p, bav, a, clr);
    @(negedge clk);
    chk(cmd_code == 3'(m_cmd), "R1", "cmd_code", cmd_code, m_cmd);
    chk(bank_open == m_vec(), tag, "bank_open", bank_open, m_vec());
    chk(viol_flag == m_flag, tag, "viol_flag", viol_flag, m_flag);
    chk(viol_code == 4'(m_code), tag, "viol_code", viol_code, m_code);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, P_NOP, 2'b00, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", wd, 150000);
      finish_run();
    end
  end

  initial begin
    model_init();
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(cmd_code == 3'd0 && bank_open == 4'd0, "R12", "cmd/bank in reset", {cmd_code, bank_open}, 0);
    chk(!viol_flag && viol_code == 4'd0, "R12", "violation in reset", viol_code, 0);
    rst_n = 1'b1;
    idle(2, "R12");

    step(0, P_ACT, 2'b01, 0, 0, "R2");               // BA0=1 -> bank 2
    chk(bank_open == 4'b0100, "R2", "BA0 high bit", bank_open, 4);
    step(0, P_RD, 2'b01, 0, 0, "R7");                // spacing 1 < tRCD
    chk(viol_flag && viol_code == 4'd3, "R7", "rcd code", viol_code, 3);
    step(0, P_NOP, 2'b00, 0, 1, "R11");
    chk(!viol_flag, "R11", "clear", viol_flag, 0);
    idle(3, "R6");
    step(0, P_ACT, 2'b10, 0, 0, "R2");               // BA1=1 -> bank 1
    chk(bank_open == 4'b0110, "R2", "BA1 low bit", bank_open, 6);
    step(0, P_ACT, 2'b11, 0, 0, "R6");               // other bank, spacing 1
    chk(viol_code == 4'd6, "R6", "rrd code", viol_code, 6);
    step(0, P_NOP, 2'b00, 0, 1, "R11");
    step(0, P_PRE, 2'b00, 1, 0, "R3");               // close all, too soon
    chk(bank_open == 4'b0000, "R3", "precharge all", bank_open, 0);
    chk(viol_code == 4'd7, "R8", "ras_min code", viol_code, 7);
    step(0, P_NOP, 2'b00, 0, 1, "R11");

    idle(4, "R4");
    step(0, P_ACT, 2'b00, 0, 0, "R4");
    idle(3, "R4");
    step(0, P_WR, 2'b00, 1, 0, "R4");                // write with auto-close
    idle(3, "R4");
    chk(bank_open[0] == 1'b1, "R4", "open before auto-close", bank_open[0], 1);
    idle(1, "R4");
    chk(bank_open[0] == 1'b0, "R4", "auto-close instant", bank_open[0], 0);
    chk(!viol_flag, "R4", "legal sequence", viol_code, 0);

    step(0, P_ACT, 2'b10, 0, 0, "R9");
    idle(3, "R9");
    step(0, P_WR, 2'b10, 0, 0, "R9");
    step(0, P_RD, 2'b10, 0, 0, "R9");                // write-to-read too soon
    chk(viol_code == 4'd9, "R9", "wtr code", viol_code, 9);
    step(0, P_NOP, 2'b00, 0, 1, "R11");
    step(0, P_PRE, 2'b10, 0, 0, "R9");               // write recovery too soon
    chk(viol_code == 4'd8, "R9", "wr code", viol_code, 8);
    chk(bank_open == 4'b0000, "R3", "single precharge", bank_open, 0);
    step(0, P_NOP, 2'b00, 0, 1, "R11");

    step(0, P_MRS, 2'b00, 0, 0, "R10");
    step(0, P_REF, 2'b00, 0, 0, "R10");
    chk(viol_code == 4'd2, "R10", "mrd code", viol_code, 2);
    step(0, P_NOP, 2'b00, 0, 1, "R11");
    step(1, P_ACT, 2'b11, 0, 0, "R1");               // deselected ACT
    chk(cmd_code == 3'd0 && bank_open == 4'd0, "R1", "deselect ignored", bank_open, 0);

    step(0, P_ACT, 2'b11, 0, 0, "R5");
    idle(3, "R5");
    step(0, P_ACT, 2'b11, 0, 0, "R5");               // ACT to open bank
    chk(viol_code == 4'd1, "R5", "illegal beats rc", viol_code, 1);
    step(0, P_NOP, 2'b00, 0, 1, "R11");
    idle(45, "R8");
    chk(viol_flag && viol_code == 4'd10, "R8", "ras_max code", viol_code, 10);
    step(0, P_NOP, 2'b00, 0, 1, "R11");
    step(0, P_PRE, 2'b00, 1, 0, "R3");
    step(0, P_NOP, 2'b00, 0, 1, "R11");

    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 4000; n++) begin
      int r;
      bit [2:0] p;
      r = int'($urandom_range(99));
      p = (r < 40) ? P_NOP : (r < 60) ? P_ACT : (r < 72) ? P_RD : (r < 84) ? P_WR :
          (r < 93) ? P_PRE : (r < 96) ? P_REF : P_MRS;
      step(($urandom_range(9) == 0), p, 2'($urandom_range(3)),
           ($urandom_range(9) < 3), ($urandom_range(19) == 0), "R11");
    end
    finish_run();
  end

endmodule